// File: doc/BRIEF.md
# Hardware Thread Context Status Controller

This block keeps the run state of a fixed number of hardware thread contexts inside a multithreaded core. Every context has a small state machine with four states: Unallocated, Active, Suspended and Halted. Per-context strobes for allocate, activate, suspend, deallocate and halt drive it. An activation does not take effect at once. It loads a per-context down-counter from a shared delay input, and the context becomes Active only when that count runs out. A suspend, deallocate or halt that arrives while the count is running cancels the activation.

Each context drives a registered issue-enable bit. Instruction issue logic may take instructions from a context only while that bit is high. Halted is a terminal state. Once every context has halted, one core-wide terminate flag rises. After reset only context 0 starts itself. The other contexts wait in Unallocated until software or a scheduler assigns a thread to them.

Top module: `thread_status_ctl`

## Requirements
- R1: While reset is held (synchronous, active low), every context reads Unallocated, every issue-enable bit is 0 and the terminate flag is 0.
- R2: If no command is given, context 0 reads Active after the first clock edge at which reset is released. Every other context stays Unallocated.
- R3: An allocate strobe moves a context from Unallocated, with no activation pending, to Suspended. In any other state an allocate strobe has no effect.
- R4: An activate strobe sampled at edge k, on a context that is Unallocated or Suspended, makes the context read Active after edge k+D. D is the value on the delay input at edge k, and a delay value of 0 acts as 1. The state does not change in between.
- R5: An activate strobe on an Active context has no effect. An activate strobe while an activation is pending restarts the count from the new delay.
- R6: A suspend strobe moves an Active context to Suspended and cancels any pending activation. On an Unallocated context it leaves the state unchanged but still cancels the pending activation.
- R7: A deallocate strobe moves any context that is not Halted to Unallocated and cancels any pending activation.
- R8: A halt strobe moves a context to Halted. A Halted context ignores every later strobe until reset.
- R9: When several strobes reach one context in the same cycle, only one of them acts. The order of precedence is halt, then deallocate, then suspend, then activate, then allocate.
- R10: The issue-enable bit of a context is 1 exactly in the cycles in which that context reads Active.
- R11: The terminate flag is 1 exactly when every context reads Halted.
- R12: Each context's state is reported in the state output at bits [2i+1:2i], where i is the context index. The codes are 0 = Unallocated, 1 = Active, 2 = Suspended and 3 = Halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_i | input | NCTX | Per-context allocate strobe |
| activate_i | input | NCTX | Per-context activate strobe |
| suspend_i | input | NCTX | Per-context suspend strobe |
| dealloc_i | input | NCTX | Per-context deallocate strobe |
| halt_i | input | NCTX | Per-context halt strobe |
| act_delay_i | input | DLY_W | Activation delay in cycles, used by every activate strobe in the same cycle |
| ctx_state_o | output | 2*NCTX | Packed per-context state codes |
| issue_en_o | output | NCTX | Per-context issue enable |
| all_halted_o | output | 1 | Core-wide terminate flag |

## Verification
Directed sequences on a three-context build exercise the following cases:
- Each lone strobe from each reachable state, which separates "acts" from "ignored".
- Delays of 0, 3 and a reloaded 4-then-2, which separate an off-by-one count from a correct one.
- Strobes combined on a single context, which expose a wrong precedence order.

A pseudo-random sweep follows. It resets the block repeatedly and drives every strobe combination and delay value. A bench model computes each context's state and counter from the requirements, and the sweep compares every output with it on every cycle. Contexts that halt one after another drive the terminate flag through both its low and high values.

// File: rtl/thread_status_pkg.sv
// Shared types for the thread context status controller.
// Assumes: state codes are fixed because software decodes them (R12).
package thread_status_pkg;

    typedef enum logic [1:0] {
        CTX_UNALLOC   = 2'd0,
        CTX_ACTIVE    = 2'd1,
        CTX_SUSPENDED = 2'd2,
        CTX_HALTED    = 2'd3
    } ctx_state_e;

    // One set of command strobes for a single context.
    typedef struct packed {
        logic halt;
        logic dealloc;
        logic susp;
        logic act;
        logic alloc;
    } ctx_cmd_t;

endpackage

// File: rtl/thread_ctx_fsm.sv
// Per-context run-state machine with a delayed-activation down-counter.
// Does: resolves the strobes by fixed precedence, counts the activation
//       delay and registers the state and the issue enable.
// Assumes: synchronous active-low reset; DLY_W >= 2; when BOOT is set,
//          a one-cycle activation is pending when reset is released.
module thread_ctx_fsm
    import thread_status_pkg::*;
#(
    parameter int DLY_W = 4,
    parameter bit BOOT  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctx_cmd_t         cmd_i,
    input  logic [DLY_W-1:0] delay_i,
    output ctx_state_e       state_o,
    output logic             issue_o
);

    localparam logic [DLY_W-1:0] CNT_ZERO = '0;
    localparam logic [DLY_W-1:0] CNT_ONE  = {{(DLY_W-1){1'b0}}, 1'b1};
    localparam logic [DLY_W-1:0] CNT_BOOT = BOOT ? CNT_ONE : CNT_ZERO;

    ctx_state_e       st_q, st_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic [DLY_W-1:0] load_val;
    logic             issue_q;

    // Purpose: a zero delay is treated as a one-cycle delay.
    always_comb load_val = (delay_i == CNT_ZERO) ? CNT_ONE : delay_i;

    // Purpose: next state and next count, with halt > dealloc > susp > act > alloc.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (st_q == CTX_HALTED) begin
            cnt_d = CNT_ZERO;
        end else if (cmd_i.halt) begin
            st_d  = CTX_HALTED;
            cnt_d = CNT_ZERO;
        end else if (cmd_i.dealloc) begin
            st_d  = CTX_UNALLOC;
            cnt_d = CNT_ZERO;
        end else if (cmd_i.susp) begin
            cnt_d = CNT_ZERO;
            if (st_q == CTX_ACTIVE) st_d = CTX_SUSPENDED;
        end else if (cmd_i.act && st_q != CTX_ACTIVE) begin
            cnt_d = load_val;
        end else if (cmd_i.alloc && st_q == CTX_UNALLOC && cnt_q == CNT_ZERO) begin
            st_d = CTX_SUSPENDED;
        end else if (cnt_q != CNT_ZERO) begin
            cnt_d = cnt_q - CNT_ONE;
            if (cnt_q == CNT_ONE) st_d = CTX_ACTIVE;
        end
    end

    // Purpose: state, count and issue-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= CTX_UNALLOC;
            cnt_q   <= CNT_BOOT;
            issue_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            issue_q <= (st_d == CTX_ACTIVE);
        end
    end

    assign state_o = st_q;
    assign issue_o = issue_q;

    // R8: Halted is terminal.
    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CTX_HALTED) |=> (st_q == CTX_HALTED));

    // R9: halt outranks every other strobe.
    assert_halt_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.halt |=> (st_q == CTX_HALTED));

    // R6: suspend never leaves the context Active.
    assert_suspend_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.susp && st_q != CTX_HALTED) |=> (st_q != CTX_ACTIVE && cnt_q == CNT_ZERO));

    // R4: Active is entered only from a count of one.
    assert_active_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CTX_ACTIVE && cnt_q != CNT_ONE) |=> (st_q != CTX_ACTIVE));

    // R10: the issue enable tracks the Active state.
    assert_issue_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_q == (st_q == CTX_ACTIVE));

endmodule

// File: rtl/thread_halt_detect.sv
// Core-wide terminate detection.
// Does: raises the flag when every context reports Halted.
// Assumes: the inputs come from registered state, so the AND does not glitch.
module thread_halt_detect #(
    parameter int NCTX = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCTX-1:0] halted_i,
    output logic            all_halted_o
);

    // Purpose: AND-reduce the per-context halted flags.
    always_comb all_halted_o = &halted_i;

    // R11: once raised, terminate stays raised until reset.
    assert_term_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        all_halted_o |=> all_halted_o);

endmodule

// File: rtl/thread_status_ctl.sv
// Top: run-state controller for NCTX hardware thread contexts.
// Does: builds one state machine per context (context 0 starts itself),
//       packs the states and drives the terminate flag.
// Assumes: all strobes and the delay are synchronous to clk.
module thread_status_ctl
    import thread_status_pkg::*;
#(
    parameter int NCTX  = 4,
    parameter int DLY_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCTX-1:0]   alloc_i,
    input  logic [NCTX-1:0]   activate_i,
    input  logic [NCTX-1:0]   suspend_i,
    input  logic [NCTX-1:0]   dealloc_i,
    input  logic [NCTX-1:0]   halt_i,
    input  logic [DLY_W-1:0]  act_delay_i,
    output logic [2*NCTX-1:0] ctx_state_o,
    output logic [NCTX-1:0]   issue_en_o,
    output logic              all_halted_o
);

    localparam int ST_W = 2;

    logic [NCTX-1:0] halted;

    for (genvar i = 0; i < NCTX; i++) begin : g_ctx
        ctx_cmd_t   cmd;
        ctx_state_e st;

        // Purpose: gather the strobes for this context.
        always_comb begin
            cmd.halt    = halt_i[i];
            cmd.dealloc = dealloc_i[i];
            cmd.susp    = suspend_i[i];
            cmd.act     = activate_i[i];
            cmd.alloc   = alloc_i[i];
        end

        thread_ctx_fsm #(
            .DLY_W (DLY_W),
            .BOOT  (i == 0)
        ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_i   (cmd),
            .delay_i (act_delay_i),
            .state_o (st),
            .issue_o (issue_en_o[i])
        );

        assign ctx_state_o[ST_W*i +: ST_W] = st;
        assign halted[i] = (st == CTX_HALTED);
    end

    thread_halt_detect #(.NCTX(NCTX)) u_done (
        .clk          (clk),
        .rst_n        (rst_n),
        .halted_i     (halted),
        .all_halted_o (all_halted_o)
    );

endmodule

// File: tb/thread_status_ctl_bench.sv
module thread_status_ctl_bench;

    localparam int NCTX  = 3;
    localparam int DLY_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCTX-1:0]   alloc = '0, act = '0, susp = '0, dealloc = '0, halt = '0;
    logic [DLY_W-1:0]  dly = '0;
    logic [2*NCTX-1:0] st_o;
    logic [NCTX-1:0]   iss_o;
    logic              term_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_st  [NCTX];
    int m_cnt [NCTX];

    always #4 clk = ~clk;

    thread_status_ctl #(.NCTX(NCTX), .DLY_W(DLY_W)) u_thread_status_ctl (
        .clk(clk), .rst_n(rst_n), .alloc_i(alloc), .activate_i(act),
        .suspend_i(susp), .dealloc_i(dealloc), .halt_i(halt),
        .act_delay_i(dly), .ctx_state_o(st_o), .issue_en_o(iss_o),
        .all_halted_o(term_o)
    );

    task automatic chk(input string tag, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    // Requirement model: codes 0 Unalloc, 1 Active, 2 Suspended, 3 Halted.
    task automatic model_edge();
        for (int i = 0; i < NCTX; i++) begin
            int d;
            d = (dly == 0) ? 1 : int'(dly);
            if (!rst_n) begin
                m_st[i] = 0; m_cnt[i] = (i == 0) ? 1 : 0;
            end else if (m_st[i] == 3) begin
                m_cnt[i] = 0;
            end else if (halt[i]) begin
                m_st[i] = 3; m_cnt[i] = 0;
            end else if (dealloc[i]) begin
                m_st[i] = 0; m_cnt[i] = 0;
            end else if (susp[i]) begin
                m_cnt[i] = 0;
                if (m_st[i] == 1) m_st[i] = 2;
            end else if (act[i] && m_st[i] != 1) begin
                m_cnt[i] = d;
            end else if (alloc[i] && m_st[i] == 0 && m_cnt[i] == 0) begin
                m_st[i] = 2;
            end else if (m_cnt[i] != 0) begin
                if (m_cnt[i] == 1) m_st[i] = 1;
                m_cnt[i] = m_cnt[i] - 1;
            end
        end
    endtask

    task automatic compare_all(input string tag);
        int all_h;
        all_h = 1;
        for (int i = 0; i < NCTX; i++) begin
            chk({tag, " state"}, int'(st_o[2*i +: 2]), m_st[i]);
            chk({"R10 issue/", tag}, int'(iss_o[i]), (m_st[i] == 1) ? 1 : 0);
            if (m_st[i] != 3) all_h = 0;
        end
        chk({"R11 terminate/", tag}, int'(term_o), all_h);
    endtask

    // One clock edge: model follows, outputs sampled 1 ns after the edge.
    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        compare_all(tag);
    endtask

    task automatic idle();
        alloc = '0; act = '0; susp = '0; dealloc = '0; halt = '0; dly = '0;
    endtask

    function automatic int sf(input int i);
        return int'(st_o[2*i +: 2]);
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        cyc("R1 reset");
        cyc("R1 reset");
        for (int i = 0; i < NCTX; i++) chk("R1 reset state", sf(i), 0);
        chk("R1 reset issue", int'(iss_o), 0);
        chk("R1 reset terminate", int'(term_o), 0);

        rst_n = 1'b1;
        cyc("R2 boot");
        chk("R2 ctx0 active", sf(0), 1);
        chk("R2 ctx1 unalloc", sf(1), 0);
        chk("R12 packed field", int'(st_o), 6'b00_00_01);

        alloc = 3'b011; cyc("R3 alloc"); idle();
        chk("R3 ctx1 suspended", sf(1), 2);
        chk("R3 ctx0 alloc ignored", sf(0), 1);

        act = 3'b010; dly = 3'd3; cyc("R4 act d3"); idle();
        chk("R4 d3 edge k", sf(1), 2);
        cyc("R4 d3"); chk("R4 d3 edge k+1", sf(1), 2);
        cyc("R4 d3"); chk("R4 d3 edge k+2", sf(1), 2);
        cyc("R4 d3"); chk("R4 d3 edge k+3", sf(1), 1);

        act = 3'b100; dly = 3'd0; cyc("R4 act d0"); idle();
        chk("R4 d0 edge k", sf(2), 0);
        cyc("R4 d0"); chk("R4 d0 edge k+1", sf(2), 1);

        act = 3'b010; dly = 3'd2; cyc("R5 act on active"); idle();
        cyc("R5"); cyc("R5");
        chk("R5 active stays", sf(1), 1);

        susp = 3'b100; cyc("R6 suspend active"); idle();
        chk("R6 active to suspended", sf(2), 2);
        act = 3'b100; dly = 3'd4; cyc("R5 reload a");
        dly = 3'd2; cyc("R5 reload b"); idle();
        cyc("R5 reload"); chk("R5 restarted not yet", sf(2), 2);
        cyc("R5 reload"); chk("R5 restarted count", sf(2), 1);

        susp = 3'b100; cyc("R6"); idle();
        act = 3'b100; dly = 3'd2; cyc("R6 pend"); idle();
        susp = 3'b100; cyc("R6 cancel"); idle();
        for (int k = 0; k < 4; k++) cyc("R6 cancelled");
        chk("R6 cancel holds", sf(2), 2);

        act = 3'b100; dly = 3'd3; cyc("R7 pend"); idle();
        dealloc = 3'b110; cyc("R7 dealloc"); idle();
        for (int k = 0; k < 4; k++) cyc("R7 cancelled");
        chk("R7 pending ctx unalloc", sf(2), 0);
        chk("R7 active ctx unalloc", sf(1), 0);

        alloc = 3'b010; act = 3'b010; susp = 3'b010; dly = 3'd1;
        cyc("R9 susp beats act"); idle();
        for (int k = 0; k < 3; k++) cyc("R9");
        chk("R9 suspend beats act/alloc", sf(1), 0);
        dealloc = 3'b001; susp = 3'b001; act = 3'b001; halt = 3'b100; alloc = 3'b100;
        act[2] = 1'b1; susp[2] = 1'b1; dealloc[2] = 1'b1;
        cyc("R9 mix"); idle();
        chk("R9 dealloc beats suspend", sf(0), 0);
        chk("R9 halt beats all", sf(2), 3);

        alloc = 3'b100; cyc("R8"); act = 3'b100; dly = 3'd1; cyc("R8");
        susp = 3'b100; cyc("R8"); dealloc = 3'b100; cyc("R8"); idle();
        cyc("R8"); cyc("R8");
        chk("R8 halted ignores strobes", sf(2), 3);
        chk("R11 not all halted", int'(term_o), 0);
        halt = 3'b011; cyc("R11 halt rest"); idle();
        chk("R11 terminate raised", int'(term_o), 1);

        // Pseudo-random sweep against the model (R9 precedence, all rules).
        for (int r = 0; r < 8; r++) begin
            rst_n = 1'b0; cyc("R1 sweep reset");
            rst_n = 1'b1;
            for (int c = 0; c < 300; c++) begin
                for (int i = 0; i < NCTX; i++) begin
                    alloc[i]   = ($urandom % 4) == 0;
                    act[i]     = ($urandom % 4) == 0;
                    susp[i]    = ($urandom % 8) == 0;
                    dealloc[i] = ($urandom % 16) == 0;
                    halt[i]    = ($urandom % (40 + 20 * r)) == 0;
                end
                dly = DLY_W'($urandom % 8);
                cyc("R9 sweep");
            end
            idle();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule